// File: doc/BRIEF.md
# Single-Bit Upset Injector Using a Shared Preset Line

This block lets a test sequence plant one flipped bit into a bank of state flip-flops while they run a workload. The workload is a plain binary counter held in the bank. Each flop has a polarity switch, and every flop shares one preset line. When that line is pulsed, each flop takes the value its own switch selects: switch 1 gives 1 and switch 0 gives 0. The D input plays no part in the upset. Only the preset line changes the flop's state.

An experiment works like this. A start pulse clears the counter and lets it step once per enabled clock. At the requested injection cycle the controller drops the run enable and captures the bank. It then rewrites the switches so that each bystander flop's switch equals that flop's current value, and the target flop's switch equals the inverse of its current value. The controller pulses the preset line for one clock and toggles back only the switches it changed. It then resumes the counter until the end cycle.

A reference run, which makes no injection, records the fault-free end value. Each later faulty run compares its end value against that record and reports the result.

Top module: `seu_inject_ctrl`

## Requirements
- R1: After reset the bank reads 0, the switches read INIT_POL (default 8'hA5, bit i is the switch of flop i), and run_en, glob_pulse, done, bad_cfg and mismatch are all 0.
- R2: A start with ref_run=1 clears the bank and counts up by one for end_cycle enabled clocks. It never pulses glob_pulse. It then raises done for exactly one clock, with reg_q = end_cycle mod 2^N and mismatch = 0.
- R3: glob_pulse is high for exactly one clock per faulty run, and run_en is 0 during that clock.
- R4: In the clock after glob_pulse, reg_q equals the captured value (inj_cycle mod 2^N) with only bit `target` inverted.
- R5: While glob_pulse is high, the switches equal the captured bank value with bit `target` inverted.
- R6: When done is high, the switches are back at INIT_POL.
- R7: A faulty run ends with reg_q = (upset value + end_cycle - inj_cycle) mod 2^N.
- R8: A faulty start with target >= N sets bad_cfg. No run takes place, reg_q and the switches are left unchanged, and done does not pulse. The next accepted start clears bad_cfg.
- R9: A faulty start with inj_cycle >= end_cycle is rejected in the same way as R8.
- R10: At the end of a faulty run, mismatch is 1 exactly when reg_q differs from the end value recorded by the most recent reference run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock pulse that begins an experiment |
| ref_run | input | 1 | 1 = fault-free reference run, 0 = faulty run |
| target | input | TW | Index of the flop to upset |
| inj_cycle | input | CW | Count of enabled steps before the upset |
| end_cycle | input | CW | Total enabled steps in the experiment |
| run_en | output | 1 | Clock enable of the workload |
| glob_pulse | output | 1 | Shared preset line |
| done | output | 1 | One-clock pulse when an experiment ends |
| bad_cfg | output | 1 | Last start was rejected |
| mismatch | output | 1 | Faulty end value differs from the reference |
| reg_q | output | N | Bank contents |
| pol_q | output | N | Polarity switch settings |

## Verification
The bench places upsets at the lowest and highest bit index and at injection cycle 0, where the controller stops before any step. It also places an upset one cycle before the end, where a slow resume would overrun the end count. A design that aligned the bystander switches wrongly would flip extra bits or clear bits at the pulse. One that failed to restore would leave the switches off INIT_POL when done is raised. Rejected configurations, with an out-of-range target or an injection cycle not before the end cycle, are checked at the ports: a design that still ran would change reg_q or pulse done. Reference runs are checked for the absence of any preset pulse and for a zero mismatch flag.

// File: rtl/seu_pkg.sv
package seu_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_RUN, S_CAPT, S_ADJ, S_PULSE, S_REST, S_FIN
    } seq_st_e;

    localparam int MAX_W = 32;

    // switch toggles that make bystanders hold and the target invert
    function automatic logic [MAX_W-1:0] align_toggles(
        input logic [MAX_W-1:0] sw,
        input logic [MAX_W-1:0] cap,
        input logic [MAX_W-1:0] tgt_1h
    );
        return sw ^ cap ^ tgt_1h;
    endfunction
endpackage

// File: rtl/wl_bank.sv
module wl_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         ce,
    input  logic         gp,
    input  logic [N-1:0] sw,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (gp)  q <= sw;
        else if (clr) q <= '0;
        else if (ce)  q <= q + 1'b1;
    end
endmodule

// File: rtl/pol_switch_bank.sv
module pol_switch_bank #(
    parameter int N = 8,
    parameter logic [N-1:0] INIT_POL = 'hA5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [N-1:0] tog,
    output logic [N-1:0] sw
);
    for (genvar i = 0; i < N; i++) begin : g_sw
        always_ff @(posedge clk) begin
            if (rst)                sw[i] <= INIT_POL[i];
            else if (we && tog[i])  sw[i] <= ~sw[i];
        end
    end
endmodule

// File: rtl/inj_seq.sv
module inj_seq
    import seu_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = 16,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          ref_run,
    input  logic [TW-1:0] target,
    input  logic [CW-1:0] inj_cycle,
    input  logic [CW-1:0] end_cycle,
    input  logic [N-1:0]  st_q,
    input  logic [N-1:0]  sw_q,
    output logic          ce,
    output logic          clr,
    output logic          gpulse,
    output logic          sw_we,
    output logic [N-1:0]  sw_tog,
    output logic          done,
    output logic          err,
    output logic          mismatch
);
    seq_st_e       st, nxt;
    logic [CW-1:0] cnt, inj_l, end_l;
    logic [TW-1:0] tgt_l;
    logic          ref_l, injected;
    logic [N-1:0]  cap, mask, refv, tgt_1h, adj;
    logic          bad;

    assign bad    = !ref_run && ((target >= TW'(N)) || (inj_cycle >= end_cycle));
    assign tgt_1h = N'(1) << tgt_l;
    assign adj    = N'(align_toggles(MAX_W'(sw_q), MAX_W'(cap), MAX_W'(tgt_1h)));

    always_comb begin
        nxt    = st;
        ce     = 1'b0;
        clr    = 1'b0;
        gpulse = 1'b0;
        sw_we  = 1'b0;
        sw_tog = '0;
        case (st)
            S_IDLE:  if (start && !bad) begin clr = 1'b1; nxt = S_RUN; end
            S_RUN: begin
                if (!ref_l && !injected && cnt == inj_l) nxt = S_CAPT;
                else if (cnt == end_l)                   nxt = S_FIN;
                else                                     ce  = 1'b1;
            end
            S_CAPT:  nxt = S_ADJ;
            S_ADJ:   begin sw_we = 1'b1; sw_tog = adj;  nxt = S_PULSE; end
            S_PULSE: begin gpulse = 1'b1;               nxt = S_REST;  end
            S_REST:  begin sw_we = 1'b1; sw_tog = mask; nxt = S_RUN;   end
            S_FIN:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE; cnt <= '0; inj_l <= '0; end_l <= '0; tgt_l <= '0;
            ref_l <= 1'b0; injected <= 1'b0; cap <= '0; mask <= '0;
            refv <= '0; done <= 1'b0; err <= 1'b0; mismatch <= 1'b0;
        end else begin
            st   <= nxt;
            done <= (st == S_FIN);
            case (st)
                S_IDLE: if (start) begin
                    err <= bad;
                    if (!bad) begin
                        ref_l <= ref_run; tgt_l <= target;
                        inj_l <= inj_cycle; end_l <= end_cycle;
                        cnt <= '0; injected <= 1'b0;
                    end
                end
                S_RUN:  if (ce) cnt <= cnt + 1'b1;
                S_CAPT: cap  <= st_q;
                S_ADJ:  mask <= adj;
                S_REST: injected <= 1'b1;
                S_FIN: begin
                    if (ref_l) begin refv <= st_q; mismatch <= 1'b0; end
                    else mismatch <= (st_q != refv);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/seu_inject_ctrl.sv
module seu_inject_ctrl #(
    parameter int N  = 8,
    parameter int CW = 16,
    parameter logic [N-1:0] INIT_POL = 'hA5,
    localparam int TW = $clog2(N) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          ref_run,
    input  logic [TW-1:0] target,
    input  logic [CW-1:0] inj_cycle,
    input  logic [CW-1:0] end_cycle,
    output logic          run_en,
    output logic          glob_pulse,
    output logic          done,
    output logic          bad_cfg,
    output logic          mismatch,
    output logic [N-1:0]  reg_q,
    output logic [N-1:0]  pol_q
);
    logic         clr, sw_we;
    logic [N-1:0] sw_tog;

    inj_seq #(.N(N), .CW(CW), .TW(TW)) u_seq (
        .clk(clk), .rst(rst), .start(start), .ref_run(ref_run),
        .target(target), .inj_cycle(inj_cycle), .end_cycle(end_cycle),
        .st_q(reg_q), .sw_q(pol_q), .ce(run_en), .clr(clr),
        .gpulse(glob_pulse), .sw_we(sw_we), .sw_tog(sw_tog),
        .done(done), .err(bad_cfg), .mismatch(mismatch)
    );

    pol_switch_bank #(.N(N), .INIT_POL(INIT_POL)) u_sw (
        .clk(clk), .rst(rst), .we(sw_we), .tog(sw_tog), .sw(pol_q)
    );

    wl_bank #(.N(N)) u_wl (
        .clk(clk), .rst(rst), .clr(clr), .ce(run_en), .gp(glob_pulse),
        .sw(pol_q), .q(reg_q)
    );
endmodule

// File: rtl/seu_inject_chk.sv
module seu_inject_chk #(
    parameter int N = 8,
    parameter logic [N-1:0] INIT_POL = 'hA5
) (
    input logic         clk,
    input logic         rst,
    input logic         run_en,
    input logic         glob_pulse,
    input logic         done,
    input logic         bad_cfg,
    input logic [N-1:0] reg_q,
    input logic [N-1:0] pol_q
);
    p_hold_en_r3: assert property (@(posedge clk) disable iff (rst)
        glob_pulse |-> !run_en);
    p_pulse_once_r3: assert property (@(posedge clk) disable iff (rst)
        glob_pulse |=> !glob_pulse);
    p_single_flip_r4: assert property (@(posedge clk) disable iff (rst)
        glob_pulse |=> ($countones(reg_q ^ $past(reg_q)) == 1));
    p_restored_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (pol_q == INIT_POL));
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_reject_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(bad_cfg) |-> ($stable(reg_q) && $stable(pol_q) && !done));
endmodule

bind seu_inject_ctrl seu_inject_chk #(.N(N), .INIT_POL(INIT_POL)) u_chk (
    .clk(clk), .rst(rst), .run_en(run_en), .glob_pulse(glob_pulse),
    .done(done), .bad_cfg(bad_cfg), .reg_q(reg_q), .pol_q(pol_q)
);

// File: tb/sim_seu_inject_ctrl.sv
module sim_seu_inject_ctrl;
    localparam int N = 8;
    localparam int CW = 16;
    localparam int TW = 4;
    localparam logic [N-1:0] INIT = 8'hA5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, ref_run = 1'b0;
    logic [TW-1:0] target = '0;
    logic [CW-1:0] inj_cycle = '0, end_cycle = '0;
    logic run_en, glob_pulse, done, bad_cfg, mismatch;
    logic [N-1:0] reg_q, pol_q;

    always #10 clk = ~clk;

    seu_inject_ctrl #(.N(N), .CW(CW), .INIT_POL(INIT)) u0 (
        .clk(clk), .rst(rst), .start(start), .ref_run(ref_run),
        .target(target), .inj_cycle(inj_cycle), .end_cycle(end_cycle),
        .run_en(run_en), .glob_pulse(glob_pulse), .done(done),
        .bad_cfg(bad_cfg), .mismatch(mismatch), .reg_q(reg_q), .pol_q(pol_q)
    );

    typedef struct packed { logic [1:0] kind; logic [8:0] val; } item_t;
    item_t exp_q[$];
    int total = 0, bad = 0, pulses = 0, dones = 0, cyc = 0;
    bit pend_st = 0, finished = 0;
    logic [N-1:0] ref_end = '0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic pop_cmp(logic [1:0] kind, logic [8:0] act, string req);
        item_t it;
        if (exp_q.size() == 0) begin
            check({req, " unexpected event"}, 32'(kind), 32'h3);
        end else begin
            it = exp_q.pop_front();
            check({req, " event kind"}, 32'(kind), 32'(it.kind));
            check(req, 32'(act), 32'(it.val));
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (pend_st) begin
                pend_st = 0;
                pop_cmp(2'd1, {1'b0, reg_q}, "R4 bank after pulse");
            end
            if (glob_pulse) begin
                pulses++;
                pop_cmp(2'd0, {1'b0, pol_q}, "R5 switches at pulse");
                check("R3 run_en low at pulse", 32'(run_en), 32'd0);
                pend_st = 1;
            end
            if (done) begin
                dones++;
                pop_cmp(2'd2, {mismatch, reg_q}, "R7 R10 end value/mismatch");
                check("R6 switches restored", 32'(pol_q), 32'(INIT));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            bad++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_exp(bit r, int t, int inj, int fin);
        logic [N-1:0] up, last;
        int p0, d0;
        p0 = pulses; d0 = dones;
        if (r) begin
            last = N'(fin);
            ref_end = last;
            exp_q.push_back({2'd2, 1'b0, last});
        end else begin
            up = N'(inj) ^ (N'(1) << t);
            last = up + N'(fin - inj);
            exp_q.push_back({2'd0, 1'b0, up});
            exp_q.push_back({2'd1, 1'b0, up});
            exp_q.push_back({2'd2, (last != ref_end), last});
        end
        @(negedge clk);
        start = 1; ref_run = r; target = TW'(t);
        inj_cycle = CW'(inj); end_cycle = CW'(fin);
        @(negedge clk);
        start = 0;
        for (int k = 0; k < 5000 && dones == d0; k++) @(negedge clk);
        check("R2 done seen", 32'(dones - d0), 32'd1);
        check(r ? "R2 no pulse in reference" : "R3 one pulse",
              32'(pulses - p0), r ? 32'd0 : 32'd1);
        check("R8 bad_cfg clear after accepted start", 32'(bad_cfg), 32'd0);
        @(negedge clk);
        check("R2 done single clock", 32'(done), 32'd0);
    endtask

    task automatic bad_exp(int t, int inj, int fin, string req);
        logic [N-1:0] s0, w0;
        int d0;
        s0 = reg_q; w0 = pol_q; d0 = dones;
        @(negedge clk);
        start = 1; ref_run = 0; target = TW'(t);
        inj_cycle = CW'(inj); end_cycle = CW'(fin);
        @(negedge clk);
        start = 0;
        repeat (4) @(negedge clk);
        check({req, " bad_cfg"}, 32'(bad_cfg), 32'd1);
        check({req, " bank unchanged"}, 32'(reg_q), 32'(s0));
        check({req, " switches unchanged"}, 32'(pol_q), 32'(w0));
        check({req, " no done"}, 32'(dones - d0), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 bank", 32'(reg_q), 32'd0);
        check("R1 switches", 32'(pol_q), 32'(INIT));
        check("R1 flags", {27'd0, run_en, glob_pulse, done, bad_cfg, mismatch}, 32'd0);

        run_exp(1, 0, 0, 20);
        run_exp(0, 0, 5, 20);
        run_exp(0, 7, 3, 20);
        run_exp(0, 3, 0, 20);
        bad_exp(9, 2, 20, "R8");
        bad_exp(8, 2, 20, "R8");
        bad_exp(2, 20, 20, "R9");
        run_exp(1, 0, 0, 300);
        run_exp(0, 5, 299, 300);
        run_exp(0, 1, 100, 300);

        check("R2 R7 scoreboard drained", 32'(exp_q.size()), 32'd0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule